// File: doc/BRIEF.md
# Frame-Memory Rectangle Transfer Walker

This block steps through a rectangle of 16-bit pixels in a frame memory that is 1024 pixels wide and 512 rows tall. It moves the rectangle to or from a 32-bit word stream. A transfer is launched by a one-cycle start strobe. The strobe comes with a position word, a size word and a direction flag. The block then splits every 32-bit word into two pixel accesses and walks left to right along each row, then down to the next row, until the whole rectangle has been covered.

The memory sees one pixel access per clock. Each access carries a pixel address, a halfword lane select and a write enable. Because of this, the producer or consumer of words is held off by a ready handshake during the first pixel of each word. When the stream pauses in the middle of a row, the column is kept, and the next word carries on from that column. For a read transfer the block raises an image-ready flag for the whole transfer. A start strobe that arrives while a transfer is still open replaces that transfer and gives a one-cycle anomaly pulse.

Top module: `vram_rect_walker`

## Requirements
- R1: On start, the origin column is taken from position bits 9:0 and the origin row from position bits 24:16. All other position bits are ignored.
- R2: Width is ((size - 1) mod 1024) + 1, using size bits 9:0, so a width field of 0 gives 1024 columns.
- R3: Height is ((size[24:16] - 1) mod 512) + 1, so a height field of 0 gives 512 rows.
- R4: Each accepted word produces two accesses on consecutive cycles. The first uses lane 0 and carries word bits 15:0. The second uses lane 1 and carries bits 31:16. word_ready is high only in the cycle of the second access, or in the cycle of the transfer's final pixel.
- R5: mem_addr equals row*1024 + ((origin column + column offset) mod 1024). The column never carries into the row part.
- R6: After the last column of a row, the row advances by one modulo 512 and the column offset returns to 0.
- R7: While word_valid is low between words, no access is made and the column offset and row are held. The next word resumes at the held column.
- R8: In the cycle after the final pixel access, busy is low and done is high for exactly one cycle. A rectangle of width*height pixels makes exactly that many accesses, and when the count is odd, the last word's upper halfword is dropped.
- R9: img_ready rises together with busy on a read start and falls together with busy when that read ends. A write start leaves it low.
- R10: A start while busy is high gives anomaly high for one cycle, and the new transfer fully replaces the old one. A start while idle gives no anomaly.
- R11: After reset, busy, done, img_ready, anomaly, mem_en and word_ready are low, and mem_en stays low whenever busy is low.
- R12: mem_we equals mem_en on a write transfer and stays low on a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch strobe |
| start_pos | input | 32 | Position word: column in 9:0, row in 24:16 |
| start_size | input | 32 | Size word: width in 9:0, height in 24:16 |
| start_rd | input | 1 | 1 = read from memory, 0 = write to memory |
| word_valid | input | 1 | A data word is present (or, when reading, a slot is wanted) |
| word_data | input | 32 | Data word, low halfword is the first pixel |
| word_ready | output | 1 | The current word is consumed at this clock edge |
| mem_en | output | 1 | Pixel access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_lane | output | 1 | Halfword lane of the word for this access |
| mem_addr | output | 19 | Pixel address, row*1024 + column |
| mem_wdata | output | 16 | Pixel to write |
| busy | output | 1 | Transfer open |
| done | output | 1 | One-cycle pulse after the final pixel |
| img_ready | output | 1 | Read transfer in progress |
| anomaly | output | 1 | One-cycle pulse: a start replaced an open transfer |

## Verification
A wrong column or row register shows up on mem_addr at the very next access. Because of that, every access is compared against an address model kept in the bench, with no tolerance. A corrupted end-of-row or row-count register is seen as an early or late done pulse, or as a pixel total different from width*height. The bench counts that total for each transfer. A phase error shows at once as a lane that does not alternate, or as word_ready in the wrong cycle, and pauses in the word stream check that the held column survives idle cycles.

// File: rtl/vram_rect_walker.sv
module vram_rect_walker #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int DW = 32,
  parameter int Y_LSB = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DW-1:0]       start_pos,
  input  logic [DW-1:0]       start_size,
  input  logic                start_rd,
  input  logic                word_valid,
  input  logic [DW-1:0]       word_data,
  output logic                word_ready,
  output logic                mem_en,
  output logic                mem_we,
  output logic                mem_lane,
  output logic [XW+YW-1:0]    mem_addr,
  output logic [DW/2-1:0]     mem_wdata,
  output logic                busy,
  output logic                done,
  output logic                img_ready,
  output logic                anomaly
);
  localparam int PW = DW / 2;

  logic [XW-1:0] x0, col, wlast;
  logic [YW-1:0] row, hrem;
  logic [PW-1:0] hi_q;
  logic          phase, rd;
  logic          row_end, last_pix, acc;

  assign row_end  = (col == wlast);
  assign last_pix = row_end && (hrem == '0);
  assign acc      = busy && !start && (phase || word_valid);

  assign mem_en     = acc;
  assign mem_we     = acc && !rd;
  assign mem_lane   = phase;
  assign mem_addr   = {row, XW'(x0 + col)};
  assign mem_wdata  = phase ? hi_q : word_data[PW-1:0];
  assign word_ready = acc && (phase || last_pix);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; img_ready <= 1'b0; anomaly <= 1'b0;
      rd <= 1'b0; phase <= 1'b0; hi_q <= '0;
      x0 <= '0; col <= '0; wlast <= '0; row <= '0; hrem <= '0;
    end else begin
      done    <= 1'b0;
      anomaly <= 1'b0;
      if (start) begin
        anomaly   <= busy;
        busy      <= 1'b1;
        rd        <= start_rd;
        img_ready <= start_rd;
        x0        <= start_pos[XW-1:0];
        row       <= start_pos[Y_LSB +: YW];
        wlast     <= start_size[XW-1:0] - XW'(1);
        hrem      <= start_size[Y_LSB +: YW] - YW'(1);
        col       <= '0;
        phase     <= 1'b0;
      end else if (acc) begin
        if (!phase) hi_q <= word_data[DW-1:PW];
        if (last_pix) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          img_ready <= 1'b0;
          phase     <= 1'b0;
        end else begin
          phase <= ~phase;
          if (row_end) begin
            col  <= '0;
            row  <= row + YW'(1);
            hrem <= hrem - YW'(1);
          end else begin
            col <= col + XW'(1);
          end
        end
      end
    end
  end
endmodule

module vram_rect_walker_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic word_ready,
  input logic mem_en,
  input logic mem_we,
  input logic mem_lane,
  input logic busy,
  input logic done,
  input logic img_ready,
  input logic anomaly
);
  // R4
  lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_lane) |-> ($past(mem_en) && !$past(mem_lane)));
  // R4
  ready_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> mem_en);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(mem_en)));
  // R9
  img_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> busy);
  // R10
  anomaly_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |-> ($past(start) && $past(busy) && busy));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
  // R12
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && busy) |-> !img_ready);
endmodule

bind vram_rect_walker vram_rect_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .word_ready(word_ready),
  .mem_en(mem_en), .mem_we(mem_we), .mem_lane(mem_lane), .busy(busy),
  .done(done), .img_ready(img_ready), .anomaly(anomaly)
);

// File: tb/sim_vram_rect_walker.sv
`timescale 1ns/1ps
module sim_vram_rect_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_pos = '0, start_size = '0;
  logic        start_rd = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready, mem_en, mem_we, mem_lane;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        busy, done, img_ready, anomaly;

  always #5 clk = ~clk;

  vram_rect_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pos(start_pos),
    .start_size(start_size), .start_rd(start_rd), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .mem_en(mem_en),
    .mem_we(mem_we), .mem_lane(mem_lane), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .img_ready(img_ready),
    .anomaly(anomaly)
  );

  function automatic int width_of(input logic [31:0] s);
    return ((int'(s[9:0]) + 1023) % 1024) + 1;
  endfunction
  function automatic int height_of(input logic [31:0] s);
    return ((int'(s[24:16]) + 511) % 512) + 1;
  endfunction

  // reference model, owned by the monitor
  int  mchecks = 0, mfails = 0, pix = 0;
  bit  ebusy = 0, erd = 0, edone = 0, eanom = 0, ephase = 0;
  int  ex0, ey, ew, erows, ecol;
  logic [31:0] ecur;

  task automatic mchk(input bit ok, input string what, input int act, input int exp);
    mchecks++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        mchk(busy == ebusy, "R8 busy", busy, ebusy);
        mchk(img_ready == (ebusy && erd), "R9 img_ready", img_ready, ebusy && erd);
        mchk(done == edone, "R8 done", done, edone);
        mchk(anomaly == eanom, "R10 anomaly", anomaly, eanom);
        edone = 0; eanom = 0;
        if (start) begin
          eanom = ebusy;
          ebusy = 1; erd = start_rd; ephase = 0; ecol = 0; pix = 0;
          ex0 = int'(start_pos[9:0]);
          ey = int'(start_pos[24:16]);
          ew = width_of(start_size);
          erows = height_of(start_size);
        end else if (ebusy) begin
          bit en_x, last;
          int xa;
          en_x = ephase || word_valid;
          mchk(mem_en == en_x, "R4/R7 mem_en", mem_en, en_x);
          if (en_x && mem_en) begin
            if (!ephase) ecur = word_data;
            last = (ecol == ew - 1) && (erows == 1);
            xa = (ey * 1024) + ((ex0 + ecol) % 1024);
            mchk(int'(mem_addr) == xa, "R5/R6/R1 mem_addr", mem_addr, xa);
            mchk(mem_lane == ephase, "R4 lane", mem_lane, ephase);
            mchk(mem_we == !erd, "R12 mem_we", mem_we, !erd);
            if (!erd)
              mchk(mem_wdata == (ephase ? ecur[31:16] : ecur[15:0]), "R4 wdata",
                   mem_wdata, ephase ? ecur[31:16] : ecur[15:0]);
            mchk(word_ready == (ephase || last), "R4/R8 word_ready", word_ready, ephase || last);
            pix++;
            if (last) begin
              ebusy = 0; edone = 1; ephase = 0;
            end else begin
              ephase = !ephase;
              if (ecol == ew - 1) begin
                ecol = 0; ey = (ey + 1) % 512; erows--;
              end else ecol++;
            end
          end
        end else begin
          mchk(mem_en == 1'b0, "R11 idle mem_en", mem_en, 0);
        end
      end
    end
  end

  int checks = 0, fails = 0;
  bit timed_out = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // called at posedge+1
  task automatic kick(input logic [31:0] p, input logic [31:0] s, input bit rd);
    start = 1; start_pos = p; start_size = s; start_rd = rd;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic put_word(input logic [31:0] d);
    bit r;
    word_valid = 1; word_data = d;
    do begin
      @(negedge clk); r = word_ready;
      @(posedge clk); #1;
    end while (!r);
    word_valid = 0;
  endtask

  task automatic finish_xfer(input int gap_max, input string tag, input int exp_pix);
    while (ebusy) begin
      put_word($urandom);
      if (gap_max > 0) begin
        int g;
        g = $urandom_range(gap_max, 0);
        repeat (g) @(posedge clk);
        #1;
      end
    end
    repeat (2) @(posedge clk); #1;
    chk(pix == exp_pix, {tag, " pixel count"}, pix, exp_pix);
    chk(busy == 0, {tag, " busy low after end"}, busy, 0);
  endtask

  function automatic logic [31:0] mk(input int lo, input int hi);
    logic [31:0] v;
    v = $urandom;
    v[9:0] = 10'(lo);
    v[24:16] = 9'(hi);
    return v;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk); #1;
    // R11 reset state
    chk(busy == 0 && done == 0 && img_ready == 0 && anomaly == 0, "R11 reset flags",
        {busy, done, img_ready, anomaly}, 0);
    chk(mem_en == 0 && word_ready == 0, "R11 reset access", {mem_en, word_ready}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    fork
      begin
        // R5 column wrap across 1023 -> 0, R1 masking of stray bits
        kick(mk(1020, 5), mk(8, 3), 0);
        finish_xfer(0, "R5 xwrap", 24);
        // R2 width field 0 means 1024, on a read (R9)
        kick(mk(0, 30), mk(0, 2), 1);
        @(negedge clk);
        chk(img_ready == 1, "R9 img_ready during read", img_ready, 1);
        @(posedge clk); #1;
        finish_xfer(0, "R2 width 1024", 2048);
        chk(img_ready == 0, "R9 img_ready cleared", img_ready, 0);
        // R3 height field 0 means 512, R6 row wraps from 511
        kick(mk(7, 500), mk(1, 0), 0);
        finish_xfer(0, "R3/R6 height 512", 512);
        // R7 pauses, R8 odd pixel count
        kick(mk(100, 200), mk(3, 3), 0);
        finish_xfer(4, "R7/R8 odd pauses", 9);
        // R10 replace an open transfer
        kick(mk(10, 10), mk(16, 4), 0);
        repeat (5) put_word($urandom);
        chk(busy == 1, "R10 old transfer open", busy, 1);
        kick(mk(50, 60), mk(5, 2), 1);
        chk(anomaly == 1, "R10 anomaly pulse", anomaly, 1);
        finish_xfer(1, "R10 replacement", 10);
        // R10 idle start makes no anomaly
        kick(mk(1, 1), mk(2, 1), 1);
        chk(anomaly == 0, "R10 no anomaly when idle", anomaly, 0);
        finish_xfer(0, "R10 idle start", 2);
        // random mix
        for (int i = 0; i < 24; i++) begin
          int w, h;
          w = $urandom_range(40, 1);
          h = $urandom_range(8, 1);
          kick(mk($urandom_range(1023, 0), $urandom_range(511, 0)), mk(w, h), $urandom_range(1, 0));
          finish_xfer(2, "R1/R2/R3 random", w * h);
        end
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    chk(!timed_out, "watchdog expired", timed_out, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule